// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block sits between a processor bus and an 8-input, 10-bit successive-approximation converter. Software writes a single control word. That word picks the input, the averaging depth and the reference, and can launch a conversion in the same write. The block then asks the converter for a power-of-two number of raw samples and sums them. It posts the truncated mean in a result register and raises a level interrupt. The interrupt drops when software reads that result.

The block also produces the converter clock from the bus clock. The low phase length and the high phase length are programmed independently, so an odd divide ratio is possible. It also keeps a 32-bit scan-rate word, reachable whole or as two 16-bit halves, and eight per-input control words. Writing zero to all of them returns the block to its reset configuration.

The converter side uses two valid/ready streams. On the request stream the block is the source: `req_valid` stays high and `req_chan`/`req_vref_int` stay stable until the converter asserts `req_ready`. On the sample stream the converter is the source: it holds `smp_valid` and `smp_data` until the block's `smp_ready` accepts them. The block raises `smp_ready` only while it waits for the sample it requested, so the converter can stall either stream for any number of cycles.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset every register reads 0, and `irq`, `adc_clk`, `req_valid` and `smp_ready` are 0.
- R2: A write to the control word (word address 0) loads the following fields: bit 0 is start, bits 3:1 are the input, bit 4 is enable, bits 7:5 are the averaging depth and bit 9 selects the internal reference. If start and enable are both 1, the write launches a conversion. On read, bit 0 is always 0 and bit 15 is a busy flag that is 1 from the cycle after the launch until the result is posted.
- R3: An averaging depth N of 0 to 4 takes exactly 2^N samples, and depths 5 to 7 act as 4. The result is the sample sum shifted right by N, with no overflow even when all 16 samples are 1023.
- R4: The result register (word address 1) returns the 10-bit result in bits 9:0, and bits 31:10 read as 0.
- R5: `irq` rises when a result is posted. It stays high until the result register is read, and is low in the cycle after that read.
- R6: A control write with start 1 and enable 0 starts nothing: `req_valid` stays 0 and busy reads 0. The written fields are still stored.
- R7: Any control-word write made while busy is dropped: the running input and depth stay unchanged, and no extra sample is requested.
- R8: The clock register (word address 2) holds the low-phase count in bits 3:0 and the high-phase count in bits 7:4. While enabled, `adc_clk` is low for the low count and high for the high count, in bus clock cycles. A count of 0 acts as 1.
- R9: While enable is 0, `adc_clk` is held low.
- R10: `req_valid` and the request fields hold until `req_ready`. `smp_ready` is high only between an accepted request and the accepted sample, and never together with `req_valid`.
- R11: The scan-rate word is at address 3, its low half at address 4 and its high half at address 5, each half in data bits 15:0. The input control words are at addresses 8 to 15. Each reads back what was written, and writing 0 restores the reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on result read) |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| irq | output | 1 | Conversion-complete level interrupt |
| adc_clk | output | 1 | Converter clock |
| req_valid | output | 1 | Sample request valid |
| req_ready | input | 1 | Converter accepts the request |
| req_chan | output | 3 | Input to convert |
| req_vref_int | output | 1 | Use internal reference |
| smp_valid | input | 1 | Converter sample valid |
| smp_ready | output | 1 | Block accepts a sample |
| smp_data | input | 10 | Raw sample |

## Verification
The bench covers the following cases:
- A depth of 7 must take 16 samples and not 128.
- Sixteen full-scale samples expose an accumulator one bit too narrow, which would post a wrapped, small result.
- A control write made in the middle of a four-sample run would switch the input during the run or restart it. A reference model of the request stream catches either fault.
- Phase counts of 3/5, 2/0 and 0/0 catch a divider that swaps the phases, that is off by one, or that stalls on zero.
- A start written with enable clear would, in a faulty design, raise a request.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int ADDR_W = 4;
  localparam int BUS_W  = 32;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL    = 4'd0,
    A_RESULT  = 4'd1,
    A_CLKDIV  = 4'd2,
    A_SCAN    = 4'd3,
    A_SCAN_LO = 4'd4,
    A_SCAN_HI = 4'd5
  } reg_addr_e;

  localparam int B_START = 0;
  localparam int B_CHAN  = 1;
  localparam int B_EN    = 4;
  localparam int B_AVG   = 5;
  localparam int B_VREF  = 9;
  localparam int B_BUSY  = 15;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} seq_state_e;
endpackage

// File: rtl/adc_clkgen.sv
module adc_clkgen #(
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [PH_W-1:0] lo_cnt,
  input  logic [PH_W-1:0] hi_cnt,
  output logic            adc_clk
);
  logic            phase_q;
  logic [PH_W-1:0] cnt_q;
  logic [PH_W-1:0] len_raw;
  logic [PH_W:0]   len_eff;
  logic [PH_W:0]   cnt_nxt;

  assign len_raw = phase_q ? hi_cnt : lo_cnt;
  assign len_eff = (len_raw == '0) ? (PH_W+1)'(1) : {1'b0, len_raw};
  assign cnt_nxt = {1'b0, cnt_q} + (PH_W+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!en) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else if (cnt_nxt >= len_eff) begin
      phase_q <= ~phase_q;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_nxt[PH_W-1:0];
    end
  end

  assign adc_clk = phase_q;
endmodule

// File: rtl/adc_sampler.sv
module adc_sampler
  import adc_seq_pkg::*;
#(
  parameter int DW      = 10,
  parameter int NCH     = 8,
  parameter int AVG_W   = 3,
  parameter int AVG_MAX = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [$clog2(NCH)-1:0] chan_i,
  input  logic                   vref_i,
  input  logic [AVG_W-1:0]       avg_i,
  output logic                   busy,
  output logic                   done,
  output logic [DW-1:0]          result,
  output logic                   req_valid,
  input  logic                   req_ready,
  output logic [$clog2(NCH)-1:0] req_chan,
  output logic                   req_vref_int,
  input  logic                   smp_valid,
  output logic                   smp_ready,
  input  logic [DW-1:0]          smp_data
);
  localparam int CH_W  = $clog2(NCH);
  localparam int ACC_W = DW + AVG_MAX;
  localparam int CNT_W = AVG_MAX + 1;

  seq_state_e       st_q;
  logic [CH_W-1:0]  chan_q;
  logic             vref_q;
  logic [AVG_W-1:0] n_q;
  logic [AVG_W-1:0] n_start;
  logic [CNT_W-1:0] taken_q;
  logic [CNT_W-1:0] last_idx;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_nxt;
  logic [DW-1:0]    result_q;
  logic             accept;

  assign n_start  = (avg_i > AVG_W'(AVG_MAX)) ? AVG_W'(AVG_MAX) : avg_i;
  assign last_idx = (CNT_W'(1) << n_q) - CNT_W'(1);
  assign accept   = (st_q == S_WAIT) && smp_valid;
  assign acc_nxt  = acc_q + ACC_W'(smp_data);
  assign done     = accept && (taken_q == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      chan_q   <= '0;
      vref_q   <= 1'b0;
      n_q      <= '0;
      taken_q  <= '0;
      acc_q    <= '0;
      result_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start) begin
          chan_q  <= chan_i;
          vref_q  <= vref_i;
          n_q     <= n_start;
          taken_q <= '0;
          acc_q   <= '0;
          st_q    <= S_REQ;
        end
        S_REQ: if (req_ready) st_q <= S_WAIT;
        S_WAIT: if (accept) begin
          acc_q <= acc_nxt;
          if (done) begin
            result_q <= DW'(acc_nxt >> n_q);
            st_q     <= S_IDLE;
          end else begin
            taken_q <= taken_q + CNT_W'(1);
            st_q    <= S_REQ;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy         = (st_q != S_IDLE);
  assign req_valid    = (st_q == S_REQ);
  assign smp_ready    = (st_q == S_WAIT);
  assign req_chan     = chan_q;
  assign req_vref_int = vref_q;
  assign result       = result_q;
endmodule

// File: rtl/adc_regfile.sv
module adc_regfile
  import adc_seq_pkg::*;
#(
  parameter int DW    = 10,
  parameter int NCH   = 8,
  parameter int AVG_W = 3,
  parameter int PH_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [BUS_W-1:0]       wdata,
  output logic [BUS_W-1:0]       rdata,
  input  logic                   busy,
  input  logic                   done,
  input  logic [DW-1:0]          result,
  output logic                   start,
  output logic [$clog2(NCH)-1:0] cfg_chan,
  output logic                   cfg_en,
  output logic [AVG_W-1:0]       cfg_avg,
  output logic                   cfg_vref,
  output logic [PH_W-1:0]        clk_lo,
  output logic [PH_W-1:0]        clk_hi,
  output logic                   irq
);
  localparam int CH_W = $clog2(NCH);
  localparam int HALF = BUS_W / 2;

  logic [BUS_W-1:0] scan_q;
  logic [BUS_W-1:0] ch_q [NCH];
  logic             ch_sel;
  logic             ctrl_wr;
  logic             res_rd;

  assign ch_sel  = addr[ADDR_W-1];
  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign res_rd  = rd_en && (addr == A_RESULT);
  assign start   = ctrl_wr && !busy && wdata[B_START] && wdata[B_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_chan <= '0;
      cfg_en   <= 1'b0;
      cfg_avg  <= '0;
      cfg_vref <= 1'b0;
      clk_lo   <= '0;
      clk_hi   <= '0;
      scan_q   <= '0;
      for (int i = 0; i < NCH; i++) ch_q[i] <= '0;
    end else if (wr_en) begin
      if (ch_sel) begin
        ch_q[addr[CH_W-1:0]] <= wdata;
      end else begin
        case (addr)
          A_CTRL: if (!busy) begin
            cfg_chan <= wdata[B_CHAN +: CH_W];
            cfg_en   <= wdata[B_EN];
            cfg_avg  <= wdata[B_AVG +: AVG_W];
            cfg_vref <= wdata[B_VREF];
          end
          A_CLKDIV: begin
            clk_lo <= wdata[0 +: PH_W];
            clk_hi <= wdata[PH_W +: PH_W];
          end
          A_SCAN:    scan_q <= wdata;
          A_SCAN_LO: scan_q[HALF-1:0] <= wdata[HALF-1:0];
          A_SCAN_HI: scan_q[BUS_W-1:HALF] <= wdata[HALF-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq <= 1'b0;
    else if (done)   irq <= 1'b1;
    else if (res_rd) irq <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    if (ch_sel) begin
      rdata = ch_q[addr[CH_W-1:0]];
    end else begin
      case (addr)
        A_CTRL: begin
          rdata[B_CHAN +: CH_W]  = cfg_chan;
          rdata[B_EN]            = cfg_en;
          rdata[B_AVG +: AVG_W]  = cfg_avg;
          rdata[B_VREF]          = cfg_vref;
          rdata[B_BUSY]          = busy;
        end
        A_RESULT:  rdata[DW-1:0] = result;
        A_CLKDIV:  rdata[2*PH_W-1:0] = {clk_hi, clk_lo};
        A_SCAN:    rdata = scan_q;
        A_SCAN_LO: rdata[HALF-1:0] = scan_q[HALF-1:0];
        A_SCAN_HI: rdata[HALF-1:0] = scan_q[BUS_W-1:HALF];
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DW      = 10,
  parameter int NCH     = 8,
  parameter int AVG_W   = 3,
  parameter int AVG_MAX = 4,
  parameter int PH_W    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [BUS_W-1:0]       wdata,
  output logic [BUS_W-1:0]       rdata,
  output logic                   irq,
  output logic                   adc_clk,
  output logic                   req_valid,
  input  logic                   req_ready,
  output logic [$clog2(NCH)-1:0] req_chan,
  output logic                   req_vref_int,
  input  logic                   smp_valid,
  output logic                   smp_ready,
  input  logic [DW-1:0]          smp_data
);
  localparam int CH_W = $clog2(NCH);

  logic             start;
  logic             seq_busy;
  logic             seq_done;
  logic [DW-1:0]    seq_result;
  logic [CH_W-1:0]  cfg_chan;
  logic             cfg_en;
  logic [AVG_W-1:0] cfg_avg;
  logic             cfg_vref;
  logic [PH_W-1:0]  clk_lo;
  logic [PH_W-1:0]  clk_hi;

  adc_regfile #(.DW(DW), .NCH(NCH), .AVG_W(AVG_W), .PH_W(PH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(seq_busy), .done(seq_done),
    .result(seq_result), .start(start), .cfg_chan(cfg_chan), .cfg_en(cfg_en),
    .cfg_avg(cfg_avg), .cfg_vref(cfg_vref), .clk_lo(clk_lo), .clk_hi(clk_hi),
    .irq(irq)
  );

  adc_clkgen #(.PH_W(PH_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .lo_cnt(clk_lo), .hi_cnt(clk_hi),
    .adc_clk(adc_clk)
  );

  adc_sampler #(.DW(DW), .NCH(NCH), .AVG_W(AVG_W), .AVG_MAX(AVG_MAX)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .chan_i(wdata[B_CHAN +: CH_W]), .vref_i(wdata[B_VREF]),
    .avg_i(wdata[B_AVG +: AVG_W]), .busy(seq_busy), .done(seq_done),
    .result(seq_result), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_vref_int(req_vref_int), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data)
  );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ctrl_wr,
  input logic            wr_en_bit,
  input logic            res_rd,
  input logic            irq,
  input logic            adc_clk,
  input logic            req_valid,
  input logic            req_ready,
  input logic [CH_W-1:0] req_chan,
  input logic            smp_ready,
  input logic            cfg_en,
  input logic            seq_busy
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_chan));

  // R10
  stream_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && smp_ready));

  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !res_rd |=> irq);

  // R9
  clk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !adc_clk);

  // R6
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy && !cfg_en && !(ctrl_wr && wr_en_bit) |=> !seq_busy);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CH_W($clog2(NCH))) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ctrl_wr(wr_en && (addr == adc_seq_pkg::A_CTRL)),
  .wr_en_bit(wdata[adc_seq_pkg::B_EN]),
  .res_rd(rd_en && (addr == adc_seq_pkg::A_RESULT)),
  .irq(irq), .adc_clk(adc_clk), .req_valid(req_valid), .req_ready(req_ready),
  .req_chan(req_chan), .smp_ready(smp_ready), .cfg_en(cfg_en),
  .seq_busy(seq_busy)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, adc_clk, req_valid, req_vref_int, smp_ready;
  logic        req_ready = 1'b0, smp_valid = 1'b0;
  logic [2:0]  req_chan;
  logic [9:0]  smp_data = '0;

  int n_chk = 0, n_bad = 0, lat_g = 1;
  int exp_q[$];
  int samp_q[$];

  always #10 clk = ~clk;

  adc_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .adc_clk(adc_clk),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .req_vref_int(req_vref_int), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    rd_en = 1'b1; addr = 4'(a);
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // Converter model and request-side monitor (scoreboard consumer)
  initial begin
    forever begin
      @(negedge clk);
      if (req_valid === 1'b1) begin
        int e;
        int v;
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 extra request", 1, 0);
          e = 0;
        end else e = exp_q.pop_front();
        check({req_vref_int, req_chan} == 4'(e), "R2/R7 request fields", {req_vref_int, req_chan}, e);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        repeat (lat_g) @(negedge clk);
        // R10: waiting for the sample, request stream idle
        check(smp_ready === 1'b1 && req_valid === 1'b0, "R10 sample wait", {smp_ready, req_valid}, 2);
        v = (samp_q.size() != 0) ? samp_q.pop_front() : 0;
        smp_data = 10'(v);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
      end
    end
  end

  task automatic wait_irq();
    int k = 0;
    while (irq !== 1'b1 && k < 2000) begin @(negedge clk); k++; end
    check(irq === 1'b1, "R5 irq raised", irq, 1);
  endtask

  // Driver: pushes the expected request stream, then checks the posted result
  task automatic conv(input int ch, input int avg, input int vref, input int base,
                      input int step, input int lat, input bit intrude);
    int n = (avg > 4) ? 4 : avg;
    int cnt = 1 << n;
    int sum = 0;
    logic [31:0] ctl, d;
    lat_g = lat;
    for (int i = 0; i < cnt; i++) begin
      int v = (base + i * step) & 1023;
      sum += v;
      samp_q.push_back(v);
      exp_q.push_back(ch | (vref << 3));
    end
    ctl = 32'(1 | (ch << 1) | (1 << 4) | (avg << 5) | (vref << 9));
    wr(0, ctl);
    rd(0, d);
    check(d[15] == 1'b1 && d[0] == 1'b0, "R2 busy set, start self-clear", d, ctl | 32'h8000);
    if (intrude) begin
      // R7: new input and start while busy
      wr(0, 32'(1 | (((ch + 3) & 7) << 1) | (1 << 4)));
    end
    wait_irq();
    repeat (3) @(negedge clk);
    check(irq === 1'b1, "R5 irq held until read", irq, 1);
    check(samp_q.size() == 0 && exp_q.size() == 0, "R3 sample count", samp_q.size(), 0);
    rd(0, d);
    check(d == (ctl & ~32'h1), intrude ? "R7 config kept" : "R2 ctrl readback", d, ctl & ~32'h1);
    rd(1, d);
    check(d[9:0] == 10'(sum >> n), "R3 averaged result", d[9:0], sum >> n);
    check(d[31:10] == '0, "R4 upper bits zero", d[31:10], 0);
    check(irq === 1'b0, "R5 irq cleared by read", irq, 0);
  endtask

  task automatic meas(input int lo, input int hi);
    int k = 0, h = 0, l = 0;
    while (adc_clk !== 1'b0 && k < 200) begin @(negedge clk); k++; end
    while (adc_clk !== 1'b1 && k < 200) begin @(negedge clk); k++; end
    while (adc_clk === 1'b1 && k < 200) begin h++; @(negedge clk); k++; end
    while (adc_clk === 1'b0 && k < 200) begin l++; @(negedge clk); k++; end
    check(h == hi, "R8 high phase", h, hi);
    check(l == lo, "R8 low phase", l, lo);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    ok = 1'b1;
    for (int a = 0; a < 16; a++) begin
      if (a == 6 || a == 7) continue;
      rd(a, d);
      if (d != 0) ok = 1'b0;
    end
    check(ok, "R1 registers zero", ok, 1);
    check(irq === 0 && adc_clk === 0 && req_valid === 0 && smp_ready === 0,
          "R1 outputs idle", {irq, adc_clk, req_valid, smp_ready}, 0);

    // R9 clock low while disabled
    ok = 1'b1;
    repeat (8) begin @(negedge clk); if (adc_clk !== 1'b0) ok = 1'b0; end
    check(ok, "R9 clock held low", ok, 1);

    // R6 start with enable clear
    wr(0, 32'h1 | (2 << 1));
    repeat (6) @(negedge clk);
    check(req_valid === 0 && irq === 0, "R6 no request", {req_valid, irq}, 0);
    rd(0, d);
    check(d == (2 << 1), "R6 fields stored, not busy", d, 2 << 1);

    // R8 clock phases
    wr(0, 32'h10);
    meas(1, 1);
    wr(2, 32'h53);
    meas(3, 5);
    wr(2, 32'h02);
    meas(2, 1);

    // Conversions
    conv(5, 0, 1, 300, 0, 1, 1'b0);
    conv(2, 2, 0, 100, 37, 2, 1'b0);
    conv(7, 4, 1, 1023, 0, 0, 1'b0);
    conv(0, 7, 0, 5, 61, 1, 1'b0);
    conv(3, 2, 1, 900, 45, 4, 1'b1);

    // R9 disable again
    wr(0, 32'h0);
    @(negedge clk);
    ok = 1'b1;
    repeat (10) begin @(negedge clk); if (adc_clk !== 1'b0) ok = 1'b0; end
    check(ok, "R9 clock low after disable", ok, 1);

    // R11 scan halves and input control words
    wr(4, 32'h1234);
    wr(5, 32'hABCD);
    rd(3, d);
    check(d == 32'hABCD1234, "R11 halves to full", d, 32'hABCD1234);
    wr(3, 32'h55AA00FF);
    rd(4, d);
    check(d == 32'h00FF, "R11 low half", d, 32'h00FF);
    rd(5, d);
    check(d == 32'h55AA, "R11 high half", d, 32'h55AA);
    wr(11, 32'hDEADBEEF);
    rd(11, d);
    check(d == 32'hDEADBEEF, "R11 input control word", d, 32'hDEADBEEF);
    wr(2, 0);
    wr(3, 0);
    for (int i = 0; i < 8; i++) wr(8 + i, 0);
    ok = 1'b1;
    for (int a = 0; a < 16; a++) begin
      if (a == 1 || a == 6 || a == 7) continue;
      rd(a, d);
      if (d != 0) ok = 1'b0;
    end
    check(ok, "R11 zero writes restore reset", ok, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule